// File: doc/BRIEF.md
# Standby Bus Access Gate

This block sits between a multiplexed processor bus and the register file of a timekeeping device and decides, bus cycle by bus cycle, whether an access is carried out or suppressed. The deciding input is a standby request that is fully asynchronous to the bus strobes. The request passes through a synchronizer and then into a capture stage. The capture stage opens when the data strobe falls and closes when the address strobe rises. Suppression therefore always starts and ends on a cycle boundary, never in the middle of a transfer.

All strobes are sampled on a fast system clock. When the address strobe rises, the block fixes the enable for the cycle that is starting and holds it until the next address-strobe rise. It turns that enable into a one-clock write commit pulse and a read drive enable for the register file. A cycle that is already running when standby arrives still completes. The cycle after it is blocked. Once standby is released, the next complete strobe pair is served again.

Top module: `stby_gate`

## Requirements
- R1: While `rst` is high, and on the clock after it is sampled high, `acc_en_o`, `wr_stb_o` and `rd_oe_o` are 0. After reset the capture stage is open and holds "standby inactive".
- R2: `stby_i` passes through SYNC_STAGES flip-flops (default 2) before it is used. With the defaults, a standby change driven together with an address-strobe rise does not affect the cycle that this rise starts.
- R3: On a data-strobe falling edge that belongs to a paired cycle, the capture stage opens. While open, it follows the synchronized standby level, so a change made between cycles takes effect at the next address-strobe rise.
- R4: An address-strobe rise (`as_i` 0 to 1) closes an open capture stage and sets `acc_en_o` to the inverse of the captured standby level. `acc_en_o` does not change until the next address-strobe rise.
- R5: If standby goes active after the address-strobe rise but before the data-strobe fall, the current cycle stays enabled and completes. The following cycle is blocked.
- R6: A standby pulse that begins and ends while the capture stage is closed has no effect on any cycle.
- R7: A data-strobe fall counts only if an address-strobe rise has occurred since the last counted fall. An address-strobe rise while the capture stage is closed keeps the previous captured level, so standby is not recognized without a full strobe pair.
- R8: In a blocked write cycle (`wr_i` = 1 at the address-strobe rise), `wr_stb_o` stays 0.
- R9: In a blocked read cycle (`wr_i` = 0 at the address-strobe rise), `rd_oe_o` stays 0.
- R10: In an enabled write cycle, `wr_stb_o` is high for exactly one clock after the data-strobe fall. In an enabled read cycle, `rd_oe_o` is high while the data strobe is high. The two are never high together.
- R11: After standby is released, the next complete address/data strobe pair is enabled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| as_i | input | 1 | Address strobe, active high; its rising edge starts a cycle |
| ds_i | input | 1 | Data strobe, active high; its falling edge ends the transfer |
| wr_i | input | 1 | 1 = write cycle, 0 = read; sampled at the address-strobe rise |
| stby_i | input | 1 | Asynchronous standby request, active high |
| acc_en_o | output | 1 | Access enable for the current cycle |
| wr_stb_o | output | 1 | One-clock write commit pulse to the register file |
| rd_oe_o | output | 1 | Read data drive enable |

## Verification
A wrong captured level, or a capture stage stuck open or stuck closed, shows at `acc_en_o` on the clock after the next address-strobe rise. It then shows again as a missing or extra `wr_stb_o` pulse or `rd_oe_o` window within the same cycle. A pairing flag left in the wrong state shows only one cycle later, because it moves the moment standby is recognized by a whole bus cycle. For that reason, the directed sequences check each cycle and also the cycle after it.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  // bit positions of the sampled strobe vector
  localparam int STB_AS = 0;
  localparam int STB_DS = 1;
  localparam int STB_WR = 2;
  localparam int STB_W  = 3;

  typedef struct packed {
    logic as_rise;
    logic ds_fall;
    logic ds_lvl;
    logic wr_lvl;
  } sbg_evt_t;
endpackage

// File: rtl/sbg_sync.sv
module sbg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[k] <= '0;
        else     stg[k] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[k] <= '0;
        else     stg[k] <= stg[k-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sbg_edge.sv
module sbg_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  if (RISING) begin : g_rise
    assign edge_o = lvl_i & ~prev_q;
  end else begin : g_fall
    assign edge_o = ~lvl_i & prev_q;
  end
endmodule

// File: rtl/sbg_latch.sv
module sbg_latch
  import sbg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  sbg_evt_t evt_i,
  input  logic     stby_s_i,
  output logic     en_o,
  output logic     paired_o,
  output logic     wr_cyc_o
);
  logic open_q;
  logic val_q;
  logic en_q;
  logic seen_q;
  logic wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b1;
      val_q  <= 1'b0;
      en_q   <= 1'b0;
      seen_q <= 1'b0;
      wr_q   <= 1'b0;
    end else if (evt_i.as_rise) begin
      seen_q <= 1'b1;
      wr_q   <= evt_i.wr_lvl;
      if (open_q) begin
        open_q <= 1'b0;
        val_q  <= stby_s_i;
        en_q   <= ~stby_s_i;
      end else begin
        en_q   <= ~val_q;
      end
    end else if (evt_i.ds_fall && seen_q) begin
      seen_q <= 1'b0;
      open_q <= 1'b1;
      val_q  <= stby_s_i;
    end else if (open_q) begin
      val_q  <= stby_s_i;
    end
  end

  assign en_o     = en_q;
  assign paired_o = seen_q;
  assign wr_cyc_o = wr_q;
endmodule

// File: rtl/stby_gate.sv
module stby_gate
  import sbg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STB_STAGES  = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic as_i,
  input  logic ds_i,
  input  logic wr_i,
  input  logic stby_i,
  output logic acc_en_o,
  output logic wr_stb_o,
  output logic rd_oe_o
);
  logic [STB_W-1:0] stb_raw;
  logic [STB_W-1:0] stb_s;
  logic             stby_s;
  logic             as_rise;
  logic             ds_fall;
  logic             en;
  logic             paired;
  logic             wr_cyc;
  sbg_evt_t         evt;

  assign stb_raw[STB_AS] = as_i;
  assign stb_raw[STB_DS] = ds_i;
  assign stb_raw[STB_WR] = wr_i;

  sbg_sync #(.W(1), .STAGES(SYNC_STAGES)) u_stby_sync (
    .clk(clk), .rst(rst), .d_i(stby_i), .q_o(stby_s)
  );

  sbg_sync #(.W(STB_W), .STAGES(STB_STAGES)) u_stb_sync (
    .clk(clk), .rst(rst), .d_i(stb_raw), .q_o(stb_s)
  );

  sbg_edge #(.RISING(1'b1)) u_as_edge (
    .clk(clk), .rst(rst), .lvl_i(stb_s[STB_AS]), .edge_o(as_rise)
  );

  sbg_edge #(.RISING(1'b0)) u_ds_edge (
    .clk(clk), .rst(rst), .lvl_i(stb_s[STB_DS]), .edge_o(ds_fall)
  );

  always_comb begin
    evt.as_rise = as_rise;
    evt.ds_fall = ds_fall;
    evt.ds_lvl  = stb_s[STB_DS];
    evt.wr_lvl  = stb_s[STB_WR];
  end

  sbg_latch u_latch (
    .clk(clk), .rst(rst), .evt_i(evt), .stby_s_i(stby_s),
    .en_o(en), .paired_o(paired), .wr_cyc_o(wr_cyc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb_o <= 1'b0;
      rd_oe_o  <= 1'b0;
    end else begin
      wr_stb_o <= evt.ds_fall & paired & en & wr_cyc;
      rd_oe_o  <= evt.ds_lvl & paired & en & ~wr_cyc;
    end
  end

  assign acc_en_o = en;
endmodule

// File: rtl/sbg_chk.sv
module sbg_chk (
  input logic clk,
  input logic rst,
  input logic as_rise,
  input logic acc_en_o,
  input logic wr_stb_o,
  input logic rd_oe_o
);
  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> (!acc_en_o && !wr_stb_o && !rd_oe_o)); // R1

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !as_rise |=> $stable(acc_en_o)); // R4

  AST_WR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |-> acc_en_o); // R8

  AST_RD_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    rd_oe_o |-> acc_en_o); // R9

  AST_WR_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |=> !wr_stb_o); // R10

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb_o && rd_oe_o)); // R10
endmodule

bind stby_gate sbg_chk u_chk (
  .clk(clk), .rst(rst), .as_rise(as_rise),
  .acc_en_o(acc_en_o), .wr_stb_o(wr_stb_o), .rd_oe_o(rd_oe_o)
);

// File: tb/tb_stby_gate.sv
module tb_stby_gate;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic as_i = 1'b0, ds_i = 1'b0, wr_i = 1'b0, stby_i = 1'b0;
  logic acc_en_o, wr_stb_o, rd_oe_o;
  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int rd_seen = 0;

  always #10 clk = ~clk;

  stby_gate dut (
    .clk(clk), .rst(rst), .as_i(as_i), .ds_i(ds_i), .wr_i(wr_i),
    .stby_i(stby_i), .acc_en_o(acc_en_o), .wr_stb_o(wr_stb_o), .rd_oe_o(rd_oe_o)
  );

  always @(posedge clk) begin
    if (wr_stb_o) wr_cnt <= wr_cnt + 1;
    if (rd_oe_o)  rd_seen <= rd_seen + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // mode: 0 none, 1 raise standby mid-cycle, 2 standby pulse in closed window,
  //       3 raise standby together with AS; as_only skips the data strobe
  task automatic bus_cycle(input string req, input logic wr, input int exp_en,
                           input int mode, input bit as_only);
    int w0, r0;
    @(negedge clk);
    w0 = wr_cnt; r0 = rd_seen;
    wr_i = wr; as_i = 1'b1;
    if (mode == 3) stby_i = 1'b1;
    wait_n(3);
    check({req, " enable after AS"}, int'(acc_en_o), exp_en);
    as_i = 1'b0;
    if (mode == 1 || mode == 2) stby_i = 1'b1;
    wait_n(3);
    if (mode == 2) stby_i = 1'b0;
    wait_n(3);
    if (!as_only) begin
      ds_i = 1'b1;
      wait_n(3);
      check({req, " read drive"}, int'(rd_oe_o), (exp_en != 0 && !wr) ? 1 : 0);
      ds_i = 1'b0;
      wait_n(3);
      check({req, " write pulses"}, wr_cnt - w0, (exp_en != 0 && wr) ? 1 : 0);
      check({req, " read clocks nonzero"}, int'(rd_seen != r0), (exp_en != 0 && !wr) ? 1 : 0);
    end
    check({req, " enable held"}, int'(acc_en_o), exp_en);
    wait_n(2);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    wait_n(3);
    check("R1 acc_en", int'(acc_en_o), 0);
    check("R1 wr_stb", int'(wr_stb_o), 0);
    check("R1 rd_oe", int'(rd_oe_o), 0);
    rst = 1'b0;
    wait_n(2);
  endtask

  task automatic t_normal;
    stby_i = 1'b0;
    bus_cycle("R10 write", 1'b1, 1, 0, 1'b0);
    bus_cycle("R10 read", 1'b0, 1, 0, 1'b0);
  endtask

  task automatic t_mid;
    bus_cycle("R5 current completes", 1'b1, 1, 1, 1'b0);
    bus_cycle("R8 blocked write", 1'b1, 0, 0, 1'b0);
    bus_cycle("R9 blocked read", 1'b0, 0, 0, 1'b0);
  endtask

  task automatic t_release;
    stby_i = 1'b0;
    wait_n(6);
    bus_cycle("R11 R3 resumed read", 1'b0, 1, 0, 1'b0);
    bus_cycle("R11 resumed write", 1'b1, 1, 0, 1'b0);
  endtask

  task automatic t_glitch;
    bus_cycle("R6 pulse cycle", 1'b1, 1, 2, 1'b0);
    bus_cycle("R6 after pulse", 1'b0, 1, 0, 1'b0);
  endtask

  task automatic t_sync;
    bus_cycle("R2 same-clock standby", 1'b1, 1, 3, 1'b0);
    bus_cycle("R2 next blocked", 1'b1, 0, 0, 1'b0);
    stby_i = 1'b0;
    wait_n(6);
    bus_cycle("R11 after R2", 1'b1, 1, 0, 1'b0);
  endtask

  task automatic t_pair;
    stby_i = 1'b0;
    bus_cycle("R7 lone AS", 1'b0, 1, 0, 1'b1);
    stby_i = 1'b1;
    wait_n(6);
    bus_cycle("R7 second lone AS", 1'b0, 1, 0, 1'b1);
    bus_cycle("R7 full pair still closed", 1'b1, 1, 0, 1'b0);
    bus_cycle("R4 captured after pair", 1'b1, 0, 0, 1'b0);
    stby_i = 1'b0;
    wait_n(6);
    bus_cycle("R11 after pairing", 1'b0, 1, 0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_mid();
    t_release();
    t_glitch();
    t_sync();
    t_pair();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule